// File: doc/BRIEF.md
# Card Presence Debounce Filter

This block cleans up the raw card-detect contact of a smart-card socket. The raw level first passes a two-stage synchronizer. A settle counter then requires the synchronized level to differ from the current debounced status, without a break, for a programmed time before the status follows it. Any return to the old level before that time runs out resets the count and leaves the status unchanged.

The settle time is a 4-bit delay value multiplied by a time unit. The unit depends on the direction of the change. A change towards "card present" uses the long unit, 8192 reference-clock cycles by default. A change towards "no card" uses the short unit, 1024 cycles by default. Both units are parameters. A delay value of zero counts as one unit.

Each confirmed change raises a sticky event flag. A read strobe from the host bus clears the flag. The interrupt output is the flag gated by a mask input.

Top module: `cdf_card_detect`

## Requirements
- R1: After synchronous active-low reset, `present_o`, `event_o` and `irq_o` are 0 and the internal count is zero.
- R2: When the raw input rises and stays high, `present_o` goes to 1 on the (2 + N·INS_UNIT)-th rising clock edge after the change, where N is `dly_i` (N = 1 when `dly_i` is 0). On the edge before that, `present_o` is still 0.
- R3: When the raw input falls and stays low, `present_o` goes to 0 on the (2 + N·EXT_UNIT)-th rising clock edge after the change, with N defined as in R2.
- R4: If the raw input returns to the level of `present_o` before the settle time runs out, the count restarts and `present_o` keeps its value. Several short excursions whose total length exceeds the settle time do not change the status.
- R5: A `dly_i` value of 0 gives a settle time of exactly one unit in each direction.
- R6: Every change of `present_o` sets `event_o` to 1 on the same edge. A cycle with `rd_clr_i` = 1 and no new change clears `event_o` on the next edge.
- R7: If a change of `present_o` and `rd_clr_i` = 1 fall on the same edge, `event_o` is 1 after that edge.
- R8: `irq_o` equals `event_o` when `mask_i` = 0 and is 0 when `mask_i` = 1.
- R9: With no change of status and no read strobe, `event_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that times the units |
| rst_n | input | 1 | Synchronous reset, active low |
| card_raw_i | input | 1 | Unfiltered card-detect contact, asynchronous |
| dly_i | input | DLY_W | Settle time in units (0 is treated as 1) |
| mask_i | input | 1 | 1 keeps the event from reaching `irq_o` |
| rd_clr_i | input | 1 | Read strobe of the event register, clears the flag |
| present_o | output | 1 | Debounced status, 1 = card present |
| event_o | output | 1 | Sticky insertion/extraction event flag |
| irq_o | output | 1 | Interrupt request, event flag gated by mask |

## Verification
The flag set caused by a confirmed status change and the clear caused by a read strobe can land on the same clock edge. The bench computes the edge on which an extraction is confirmed and pulses `rd_clr_i` in exactly that cycle. At that moment the flag is already set from an earlier unread event, so a design in which the clear wins would show 0. The flag must read 1 afterwards and the status must have changed. A separate read in a quiet cycle must then bring the flag to 0.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

  // Effective unit count: a programmed zero still waits one unit.
  function automatic int unsigned eff_units(input int unsigned dly);
    return (dly == 0) ? 1 : dly;
  endfunction

  // Cycles the synchronized level must hold before the status follows it.
  function automatic int unsigned settle_len(input int unsigned dly,
                                             input bit          to_present,
                                             input int unsigned ext_unit,
                                             input int unsigned ins_unit);
    return eff_units(dly) * (to_present ? ins_unit : ext_unit);
  endfunction

  function automatic int unsigned max_unit(input int unsigned a,
                                           input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cdf_sync.sv
module cdf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdf_settle_timer.sv
module cdf_settle_timer
  import cdf_pkg::*;
#(
  parameter int unsigned DLY_W    = 4,
  parameter int unsigned EXT_UNIT = 1024,
  parameter int unsigned INS_UNIT = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             status_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             commit_o
);
  localparam int unsigned MAX_LEN = ((1 << DLY_W) - 1) * max_unit(EXT_UNIT, INS_UNIT);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             differ;

  assign differ   = (level_i != status_i);
  assign limit    = CNT_W'(settle_len(32'(dly_i), level_i, EXT_UNIT, INS_UNIT));
  // >= keeps a shortened delay from letting the count run past its target
  assign commit_o = differ && (cnt_q >= (limit - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!differ || commit_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < MAX_LEN); // R2

  AST_RESTART_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == status_i) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/cdf_event_flag.sv
module cdf_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_i;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R7

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_q)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |-> !irq_o); // R8

endmodule

// File: rtl/cdf_card_detect.sv
module cdf_card_detect #(
  parameter int unsigned DLY_W       = 4,
  parameter int unsigned EXT_UNIT    = 1024,
  parameter int unsigned INS_UNIT    = 8192,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_raw_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             mask_i,
  input  logic             rd_clr_i,
  output logic             present_o,
  output logic             event_o,
  output logic             irq_o
);
  logic level_sync;
  logic commit;
  logic present_q;

  cdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (card_raw_i),
    .q_o   (level_sync)
  );

  cdf_settle_timer #(
    .DLY_W    (DLY_W),
    .EXT_UNIT (EXT_UNIT),
    .INS_UNIT (INS_UNIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level_sync),
    .status_i (present_q),
    .dly_i    (dly_i),
    .commit_o (commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      present_q <= 1'b0;
    else if (commit) present_q <= level_sync;
  end

  cdf_event_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (commit),
    .clr_i  (rd_clr_i),
    .mask_i (mask_i),
    .flag_o (event_o),
    .irq_o  (irq_o)
  );

  assign present_o = present_q;

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(present_q)); // R4

  AST_COMMIT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (present_q != $past(present_q))); // R2

  AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> event_o); // R6

endmodule

// File: tb/tb_cdf_card_detect.sv
module tb_cdf_card_detect;
  localparam int unsigned EXT_U = 4;
  localparam int unsigned INS_U = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_raw_i = 1'b0;
  logic [3:0] dly_i = 4'd0;
  logic       mask_i = 1'b0;
  logic       rd_clr_i = 1'b0;
  logic       present_o, event_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cdf_card_detect #(.DLY_W(4), .EXT_UNIT(EXT_U), .INS_UNIT(INS_U)) dut (
    .clk(clk), .rst_n(rst_n), .card_raw_i(card_raw_i), .dly_i(dly_i),
    .mask_i(mask_i), .rd_clr_i(rd_clr_i),
    .present_o(present_o), .event_o(event_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // Settle length restated from the requirements.
  function automatic int bench_len(int d, bit up);
    int n;
    n = (d < 1) ? 1 : d;
    return up ? n * INS_U : n * EXT_U;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    edges(3);
    chk("R1 present", present_o, 1'b0);
    chk("R1 event", event_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    rst_n = 1'b1;
    edges(1);
  endtask

  // Full transition with timing check one edge before and on the commit edge.
  task automatic t_change(string req, bit lvl, int d);
    int len;
    len = bench_len(d, lvl);
    dly_i = 4'(d);
    card_raw_i = lvl;
    edges(len + 1);
    chk({req, " before"}, present_o, ~lvl);
    edges(1);
    chk({req, " after"}, present_o, lvl);
    chk({req, " flag"}, event_o, 1'b1);
  endtask

  task automatic t_mask;
    mask_i = 1'b1;
    edges(1);
    chk("R8 masked", irq_o, 1'b0);
    mask_i = 1'b0;
    edges(1);
    chk("R8 unmasked", irq_o, 1'b1);
  endtask

  task automatic t_read_clear;
    rd_clr_i = 1'b1;
    edges(1);
    rd_clr_i = 1'b0;
    chk("R6 cleared", event_o, 1'b0);
    chk("R6 irq", irq_o, 1'b0);
  endtask

  // Status is 1 here; extraction window with dly 3 is 12 cycles.
  task automatic t_glitch;
    dly_i = 4'd3;
    card_raw_i = 1'b0; edges(6);
    card_raw_i = 1'b1; edges(30);
    chk("R4 short drop", present_o, 1'b1);
    card_raw_i = 1'b0; edges(8);
    card_raw_i = 1'b1; edges(2);
    card_raw_i = 1'b0; edges(8);
    card_raw_i = 1'b1; edges(30);
    chk("R4 restart", present_o, 1'b1);
    chk("R4 no event", event_o, 1'b0);
  endtask

  task automatic t_sticky;
    edges(20);
    chk("R9 held", event_o, 1'b1);
  endtask

  // Extraction with dly 0 while the flag is already set; read lands on commit edge.
  task automatic t_set_wins;
    int len;
    len = bench_len(0, 1'b0);
    dly_i = 4'd0;
    card_raw_i = 1'b0;
    edges(len + 1);
    chk("R5 ext before", present_o, 1'b1);
    rd_clr_i = 1'b1;
    edges(1);
    rd_clr_i = 1'b0;
    chk("R5 ext after", present_o, 1'b0);
    chk("R7 set wins", event_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_change("R2 insert d3", 1'b1, 3);
    t_mask();
    t_read_clear();
    t_glitch();
    t_change("R3 extract d3", 1'b0, 3);
    t_change("R5 insert d0", 1'b1, 0);
    t_sticky();
    t_set_wins();
    t_read_clear();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule